// File: doc/BRIEF.md
# Processor Arithmetic and Logic Unit

This block is the 32-bit arithmetic and logic unit of a small processor datapath. It is purely combinational. Two operand words and a 4-bit function code go in, and one result word comes out in the same cycle. The caller selects the operands, whether from the register file or from a sign-extended literal, so the unit never sees where a value came from.

The unit provides the following operations:

- Modular addition and subtraction.
- Three signed comparisons that return a 0/1 word.
- The four bitwise functions: AND, OR, XOR and XNOR.
- Three shifts, with the amount taken from the low five bits of the second operand.

The multiply and divide codes, and the other unused codes, produce a zero word. An enclosing pipeline can therefore route every code through the unit without special handling.

Top module: `alu_word_unit`

## Requirements
- R1: The function code encodes the operations as follows: 0000 add, 0001 subtract, 0100 equal, 0101 less-than, 0110 less-or-equal, 1000 AND, 1001 OR, 1010 XOR, 1011 XNOR, 1100 shift left, 1101 logical shift right, 1110 arithmetic shift right.
- R2: Add returns (A + B) mod 2^32. For example, 0xDEADBEEF + 0x73FF0008 = 0x52ACBEF7 and 0xFFFFFFFF + 1 = 0.
- R3: Subtract returns (A - B) mod 2^32. For example, 0xDEADBEEF - 0xFFFFFFFF = 0xDEADBEF0.
- R4: Every comparison returns exactly 0x00000001 when true and 0x00000000 when false. The equal compare is true only when the two operands are bitwise identical.
- R5: Less-than and less-or-equal treat both operands as two's-complement numbers. They stay correct when the operands have opposite signs and the difference overflows.
- R6: AND, OR, XOR and XNOR act bit by bit. For example, XNOR of 0xDEADBEEF and 0x73FF0008 is 0x52AD4118.
- R7: Shift left moves A left by B[4:0] places and fills with zeros. B[31:5] is ignored, so an amount of 32 returns A unchanged.
- R8: Logical shift right moves A right by B[4:0] places with zero fill. For example, 0xDEADBEEF shifted by 6 gives 0x037AB6FB.
- R9: Arithmetic shift right fills with copies of A[31]. For example, 0xDEADBEEF shifted by 7 gives 0xFFBD5B7D.
- R10: Codes 0010, 0011, 0111 and 1111 return 0x00000000 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, or the shift amount in its low 5 bits |
| fn_code | input | 4 | Operation select |
| result | output | 32 | Operation result |

## Verification
The bench goes after the following corner cases:

- **Signed compares whose subtraction overflows**, such as 0x80000000 against 1. A design that compared on the raw difference sign would invert the answer here.
- **Shift amounts of 32 and 33.** A design that used more than five amount bits would return zero instead of the operand.
- **Arithmetic shifts of negative words.** A design that lost the sign fill would return a small positive number.
- **Unused codes.** The bench confirms that these codes yield a zero word rather than leaking a neighbouring operation's output.

Random operands of every code are then compared against a behavioural model written in the bench.

// File: rtl/alu_word_pkg.sv
// Package: alu_word_pkg
// Holds the function-code encoding shared by the unit, its checker and users.
// Assumes a 4-bit code; the low two bits pick the variant within a group.
package alu_word_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'b0000,
        FN_SUB  = 4'b0001,
        FN_MULZ = 4'b0010,
        FN_DIVZ = 4'b0011,
        FN_CEQ  = 4'b0100,
        FN_CLT  = 4'b0101,
        FN_CLE  = 4'b0110,
        FN_U7   = 4'b0111,
        FN_AND  = 4'b1000,
        FN_OR   = 4'b1001,
        FN_XOR  = 4'b1010,
        FN_XNOR = 4'b1011,
        FN_SHL  = 4'b1100,
        FN_SHR  = 4'b1101,
        FN_SRA  = 4'b1110,
        FN_U15  = 4'b1111
    } alu_fn_e;

    // Group decode of the two upper code bits.
    localparam logic [1:0] GRP_ARITH = 2'b00;
    localparam logic [1:0] GRP_CMP   = 2'b01;
    localparam logic [1:0] GRP_LOGIC = 2'b10;
    localparam logic [1:0] GRP_SHIFT = 2'b11;

endpackage

// File: rtl/alu_prefix_adder.sv
// Module: alu_prefix_adder
// Parallel-prefix adder/subtractor. In subtract mode B is inverted and the
// carry-in forced to one. Exposes the sum and the signed-overflow flag.
// Assumes WIDTH is a power of two of at least 2.
module alu_prefix_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] add_sum,
    output logic             add_ovf
);
    localparam int LVLS = $clog2(WIDTH);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] p_raw;
    logic [WIDTH-1:0] g_lvl [0:LVLS];
    logic [WIDTH-1:0] p_lvl [0:LVLS];
    logic [WIDTH:0]   carry;

    // Operand conditioning: invert B for subtraction.
    assign b_eff = sub_mode ? ~add_b : add_b;
    assign p_raw = add_a ^ b_eff;

    // Level-0 generate/propagate, with the carry-in folded into bit 0.
    assign g_lvl[0][0] = (add_a[0] & b_eff[0]) | (p_raw[0] & sub_mode);
    assign p_lvl[0][0] = p_raw[0];
    generate
        for (genvar i = 1; i < WIDTH; i++) begin : g_init
            assign g_lvl[0][i] = add_a[i] & b_eff[i];
            assign p_lvl[0][i] = p_raw[i];
        end

        // Log-depth prefix network combining groups at doubling distance.
        for (genvar k = 0; k < LVLS; k++) begin : g_lvl_k
            localparam int DIST = 1 << k;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                if (i >= DIST) begin : g_comb
                    assign g_lvl[k+1][i] = g_lvl[k][i] | (p_lvl[k][i] & g_lvl[k][i-DIST]);
                    assign p_lvl[k+1][i] = p_lvl[k][i] & p_lvl[k][i-DIST];
                end else begin : g_pass
                    assign g_lvl[k+1][i] = g_lvl[k][i];
                    assign p_lvl[k+1][i] = p_lvl[k][i];
                end
            end
        end

        // Carry into each bit is the group generate of all bits below it.
        assign carry[0] = sub_mode;
        for (genvar i = 1; i <= WIDTH; i++) begin : g_carry
            assign carry[i] = g_lvl[LVLS][i-1];
        end
    endgenerate

    // Sum bits and signed overflow from the top two carries.
    assign add_sum = p_raw ^ carry[WIDTH-1:0];
    assign add_ovf = carry[WIDTH] ^ carry[WIDTH-1];

endmodule

// File: rtl/alu_compare.sv
// Module: alu_compare
// Signed compare from a subtraction: equality from a zero difference,
// less-than from sign XOR overflow. Emits a 0/1 word.
// Assumes the adder is in subtract mode whenever a compare code is applied.
module alu_compare #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] diff,
    input  logic             diff_ovf,
    input  logic [1:0]       cmp_sel,
    output logic [WIDTH-1:0] cmp_word
);
    logic is_eq;
    logic is_lt;
    logic hit;

    // Flags derived from the difference.
    assign is_eq = (diff == '0);
    assign is_lt = diff[WIDTH-1] ^ diff_ovf;

    // Select the relation requested by the low code bits.
    always_comb begin
        unique case (cmp_sel)
            2'b00:   hit = is_eq;
            2'b01:   hit = is_lt;
            2'b10:   hit = is_lt | is_eq;
            default: hit = 1'b0;
        endcase
    end

    // Widen the single flag to a word.
    assign cmp_word = {{(WIDTH-1){1'b0}}, hit};

endmodule

// File: rtl/alu_bitlogic.sv
// Module: alu_bitlogic
// Bitwise logic as a per-bit 4-entry truth table chosen by the low code bits
// (00 AND, 01 OR, 10 XOR, 11 XNOR). Assumes nothing about operand values.
module alu_bitlogic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lg_a,
    input  logic [WIDTH-1:0] lg_b,
    input  logic [1:0]       lg_sel,
    output logic [WIDTH-1:0] lg_out
);
    logic [3:0] tt;

    // Truth table indexed by {a,b}: bit 3 is a=1,b=1; bit 0 is a=0,b=0.
    always_comb begin
        unique case (lg_sel)
            2'b00:   tt = 4'b1000;
            2'b01:   tt = 4'b1110;
            2'b10:   tt = 4'b0110;
            default: tt = 4'b1001;
        endcase
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign lg_out[i] = tt[{lg_a[i], lg_b[i]}];
        end
    endgenerate

endmodule

// File: rtl/alu_barrel_shift.sv
// Module: alu_barrel_shift
// Log-stage right shifter; left shifts reuse it by reversing bit order on
// the way in and out. sh_sel: 00 left, 01 logical right, 10 arithmetic right.
// Assumes only the low log2(WIDTH) bits of the amount matter.
module alu_barrel_shift #(
    parameter int WIDTH = 32,
    localparam int AMTW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] sh_in,
    input  logic [AMTW-1:0]  sh_amt,
    input  logic [1:0]       sh_sel,
    output logic [WIDTH-1:0] sh_out
);
    logic             go_left;
    logic             fill;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stg [0:AMTW];

    // Direction and fill bit.
    assign go_left = (sh_sel == 2'b00);
    assign fill    = (sh_sel == 2'b10) ? sh_in[WIDTH-1] : 1'b0;

    generate
        // Bit reversal of the input for left shifts.
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
            assign rev_in[i] = sh_in[WIDTH-1-i];
        end

        assign stg[0] = go_left ? rev_in : sh_in;

        // One stage per amount bit, shifting by a power of two.
        for (genvar k = 0; k < AMTW; k++) begin : g_stage
            localparam int D = 1 << k;
            assign stg[k+1] = sh_amt[k] ? {{D{fill}}, stg[k][WIDTH-1:D]} : stg[k];
        end

        // Undo the reversal on the way out.
        for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
            assign rev_out[i] = stg[AMTW][WIDTH-1-i];
        end
    endgenerate

    assign sh_out = go_left ? rev_out : stg[AMTW];

endmodule

// File: rtl/alu_word_unit.sv
// Module: alu_word_unit (top)
// Combinational ALU: add, subtract, signed compares, bitwise logic, shifts.
// Operand selection is done by the caller; unused codes return zero.
// Assumes fn_code is stable while result is consumed; no clock or state.
module alu_word_unit #(
    parameter int WIDTH = 32,
    localparam int AMTW = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       fn_code,
    output logic [WIDTH-1:0] result
);
    import alu_word_pkg::*;

    logic             use_sub;
    logic [WIDTH-1:0] sum_w;
    logic             ovf_w;
    logic [WIDTH-1:0] cmp_w;
    logic [WIDTH-1:0] log_w;
    logic [WIDTH-1:0] shf_w;

    // Subtract for SUB and for every compare.
    assign use_sub = (fn_code == FN_SUB) || (fn_code[3:2] == GRP_CMP);

    alu_prefix_adder #(.WIDTH(WIDTH)) u_add (
        .add_a    (op_a),
        .add_b    (op_b),
        .sub_mode (use_sub),
        .add_sum  (sum_w),
        .add_ovf  (ovf_w)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .diff     (sum_w),
        .diff_ovf (ovf_w),
        .cmp_sel  (fn_code[1:0]),
        .cmp_word (cmp_w)
    );

    alu_bitlogic #(.WIDTH(WIDTH)) u_log (
        .lg_a   (op_a),
        .lg_b   (op_b),
        .lg_sel (fn_code[1:0]),
        .lg_out (log_w)
    );

    alu_barrel_shift #(.WIDTH(WIDTH)) u_shf (
        .sh_in  (op_a),
        .sh_amt (op_b[AMTW-1:0]),
        .sh_sel (fn_code[1:0]),
        .sh_out (shf_w)
    );

    // Final result select; unused codes drive zero.
    always_comb begin
        unique case (fn_code)
            FN_ADD, FN_SUB:                 result = sum_w;
            FN_CEQ, FN_CLT, FN_CLE:         result = cmp_w;
            FN_AND, FN_OR, FN_XOR, FN_XNOR: result = log_w;
            FN_SHL, FN_SHR, FN_SRA:         result = shf_w;
            default:                        result = '0;
        endcase
    end

endmodule

// File: rtl/alu_word_unit_chk.sv
// Module: alu_word_unit_chk
// Assertion checker bound to alu_word_unit. The unit is combinational, so
// the checks are immediate and evaluated on every settled input change.
module alu_word_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [3:0]       fn_code,
    input logic [WIDTH-1:0] result
);
    // Operation-level invariants checked after each input change.
    always_comb begin
        // R2
        if (fn_code == 4'b0000) begin
            add_inverse_chk: assert (result - op_b == op_a);
        end
        // R3
        if (fn_code == 4'b0001) begin
            sub_inverse_chk: assert (result + op_b == op_a);
        end
        // R4
        if (fn_code == 4'b0100 || fn_code == 4'b0101 || fn_code == 4'b0110) begin
            cmp_bool_chk: assert (result[WIDTH-1:1] == '0);
        end
        // R6
        if (fn_code == 4'b1011) begin
            xnor_word_chk: assert (result == ~(op_a ^ op_b));
        end
        // R9
        if (fn_code == 4'b1110 && op_a[WIDTH-1]) begin
            sra_sign_chk: assert (result[WIDTH-1]);
        end
        // R10
        if (fn_code == 4'b0010 || fn_code == 4'b0011 || fn_code == 4'b0111 || fn_code == 4'b1111) begin
            unused_zero_chk: assert (result == '0);
        end
    end
endmodule

bind alu_word_unit alu_word_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .fn_code (fn_code),
    .result  (result)
);

// File: tb/tb_alu_word_unit.sv
// Bench for alu_word_unit: a vector table walked by one loop, directed
// corner cases, then random vectors against a behavioural model.
module tb_alu_word_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  fn_code = '0;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    alu_word_unit dut (
        .op_a    (op_a),
        .op_b    (op_b),
        .fn_code (fn_code),
        .result  (result)
    );

    typedef struct packed {
        logic [3:0]  fn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VT [NV] = '{
        '{4'b0000, 32'hDEADBEEF, 32'h73FF0008, 32'h52ACBEF7},
        '{4'b0000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
        '{4'b0001, 32'hDEADBEEF, 32'h73FF0008, 32'h6AAEBEE7},
        '{4'b0001, 32'hDEADBEEF, 32'hFFFFFFFF, 32'hDEADBEF0},
        '{4'b0100, 32'hDEADBEEF, 32'hDEADBEEF, 32'h00000001},
        '{4'b0100, 32'hDEADBEEF, 32'h73FF0008, 32'h00000000},
        '{4'b0101, 32'hDEADBEEF, 32'h73FF0008, 32'h00000001},
        '{4'b0101, 32'h73FF0008, 32'hDEADBEEF, 32'h00000000},
        '{4'b0101, 32'h80000000, 32'h00000001, 32'h00000001},
        '{4'b0101, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000},
        '{4'b0101, 32'h00000005, 32'h00000005, 32'h00000000},
        '{4'b0110, 32'h00000005, 32'h00000005, 32'h00000001},
        '{4'b0110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000},
        '{4'b0110, 32'h80000000, 32'h7FFFFFFF, 32'h00000001},
        '{4'b1000, 32'hDEADBEEF, 32'h73FF0008, 32'h52AD0008},
        '{4'b1001, 32'hDEADBEEF, 32'h73FF0008, 32'hFFFFBEEF},
        '{4'b1010, 32'hDEADBEEF, 32'h73FF0008, 32'hAD52BEE7},
        '{4'b1011, 32'hDEADBEEF, 32'h73FF0008, 32'h52AD4118},
        '{4'b1100, 32'h73FF0008, 32'h00000004, 32'h3FF00080},
        '{4'b1100, 32'h73FF0008, 32'h00000020, 32'h73FF0008},
        '{4'b1100, 32'h73FF0008, 32'h00000021, 32'hE7FE0010},
        '{4'b1101, 32'h73FF0008, 32'h00000004, 32'h073FF000},
        '{4'b1101, 32'hDEADBEEF, 32'h00000006, 32'h037AB6FB},
        '{4'b1110, 32'hDEADBEEF, 32'h00000007, 32'hFFBD5B7D},
        '{4'b1110, 32'h73FF0008, 32'h00000004, 32'h073FF000},
        '{4'b0010, 32'hDEADBEEF, 32'h73FF0008, 32'h00000000},
        '{4'b0111, 32'hDEADBEEF, 32'h73FF0008, 32'h00000000},
        '{4'b1111, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
    };

    // Requirement tag for each code (R1 holds the encoding itself).
    function automatic string req_of(input logic [3:0] f);
        case (f)
            4'b0000: return "R1/R2";
            4'b0001: return "R1/R3";
            4'b0100: return "R1/R4";
            4'b0101, 4'b0110: return "R1/R5";
            4'b1000, 4'b1001, 4'b1010, 4'b1011: return "R1/R6";
            4'b1100: return "R1/R7";
            4'b1101: return "R1/R8";
            4'b1110: return "R1/R9";
            default: return "R10";
        endcase
    endfunction

    // Behavioural model written from the requirements.
    function automatic logic [31:0] model(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        int sh = int'(b[4:0]);
        case (f)
            4'b0000: return a + b;
            4'b0001: return a - b;
            4'b0100: return (a == b) ? 32'd1 : 32'd0;
            4'b0101: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'b0110: return ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
            4'b1000: return a & b;
            4'b1001: return a | b;
            4'b1010: return a ^ b;
            4'b1011: return ~(a ^ b);
            4'b1100: return a << sh;
            4'b1101: return a >> sh;
            4'b1110: return 32'($signed(a) >>> sh);
            default: return 32'd0;
        endcase
    endfunction

    // Apply one vector and compare away from the clock edge.
    task automatic check(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp, input string tag);
        @(negedge clk);
        fn_code = f;
        op_a = a;
        op_b = b;
        #1;
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s fn=%b a=%h b=%h actual=%h expected=%h", tag, f, a, b, result, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: all-zero inputs select add and give zero (R2).
        #1;
        total++;
        if (result !== 32'h0) begin
            bad++;
            $display("FAIL R2 idle actual=%h expected=%h", result, 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            check(VT[i].fn, VT[i].a, VT[i].b, VT[i].exp, req_of(VT[i].fn));
        end

        // Directed shift extremes.
        check(4'b1110, 32'h80000000, 32'd31, 32'hFFFFFFFF, "R9 sra by 31");
        check(4'b1101, 32'h80000000, 32'd31, 32'h00000001, "R8 shr by 31");
        check(4'b1100, 32'h00000001, 32'd31, 32'h80000000, "R7 shl by 31");
        check(4'b1100, 32'h12345678, 32'hFFFFFFE0, 32'h12345678, "R7 upper amount bits ignored");
        check(4'b0011, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, "R10 divide code");
        check(4'b0101, 32'h80000000, 32'h80000000, 32'h00000000, "R5 most negative equal");
        check(4'b0100, 32'h00000000, 32'h80000000, 32'h00000000, "R4 zero vs sign bit");

        // Random vectors over every code.
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  f = 4'($urandom_range(0, 15));
            logic [31:0] a = $urandom;
            logic [31:0] b = (n % 4 == 0) ? a : $urandom;
            check(f, a, b, model(f, a, b), req_of(f));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule